// File: doc/BRIEF.md
# Four-Stage Floating-Point Adder Pipeline

This block adds or subtracts two floating-point operands held in a simple normalized sign-magnitude format. Each operand word has a sign bit, an unsigned exponent and a fraction significand. The binary point sits to the left of the fraction's top bit, so a nonzero normalized significand lies in [1/2, 1). An operand whose fraction is zero stands for zero, whatever its exponent.

The work is split into four registered segments that always run in the same order. The first compares the operands, the second aligns the smaller one, the third adds or subtracts the significands, and the fourth normalizes the result. The alignment and normalization shifts are combinational barrel shifters. The block accepts a new operation on every clock, and each result leaves the last segment exactly four clocks after its operands went in.

Inside the segments the behaviour is described by named cases. The comparison stage sets the operation kind to OP_ADD when the effective signs match and to OP_SUB when they differ. The normalization stage picks one of four cases: NORM_ZERO (the sum is zero), NORM_CARRY (the addition carried out), NORM_FLUSH (the exponent is too small for the left shift) and NORM_LEFT (an ordinary left shift by the leading-zero count). Each case leads to exactly one way of forming the result word.

Top module: `fpa_pipe4`

## Requirements
- R1: An operand or result word is 25 bits: bit 24 is the sign, bits 23:16 the unsigned exponent e, and bits 15:0 the fraction f. The value is (-1)^sign × (f / 2^16) × 2^e. A word whose fraction is zero is zero.
- R2: With `in_sub` = 0 the block computes A + B. With `in_sub` = 1 it computes A − B, which it does by inverting the sign of B.
- R3: `out_vld` and `out_res` for an input accepted on clock edge k appear after edge k+4. A new operation can be accepted on every clock, back to back.
- R4: The operand with the smaller magnitude has its fraction shifted right by the exponent difference, and the result takes the larger exponent. Shifted-out bits are truncated. A difference of 16 or more leaves no contribution.
- R5: When the exponents are equal, the smaller operand's fraction is used without any shift.
- R6: When the significand sum carries out of bit 15, the sum is shifted right by one and the exponent is increased by one.
- R7: When the sum has leading zeros, it is shifted left until bit 15 is 1, and the exponent is reduced by the shift amount.
- R8: A zero significand result, including exact cancellation, is output as the all-zero word (positive sign, zero exponent).
- R9: If the leading-zero count exceeds the exponent, the result is flushed to the all-zero word.
- R10: The result takes the sign of the operand with the larger magnitude, after the sign of B has been inverted for subtraction. When the magnitudes are equal, A counts as the larger.
- R11: While reset is asserted, and until the first result arrives, `out_vld` is 0 and `out_res` is 0.
- R12: Every valid nonzero result has bit 15 (the top fraction bit) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands present this clock |
| in_sub | input | 1 | 1 = subtract B from A, 0 = add |
| in_a | input | 25 | Operand A |
| in_b | input | 25 | Operand B |
| out_vld | output | 1 | Result present |
| out_res | output | 25 | Normalized result |

## Verification
Every result is due on the fourth rising edge after its operands are driven. The bench drives on falling edges and keeps a queue of expected valid flags and words, which it fills from a behavioural integer model. On each falling edge it pops the entry that was pushed four falling edges earlier and compares it with the outputs, so a result that comes early or late is reported as a mismatch. Directed vectors cover carry, cancellation, flush-to-zero, large exponent gaps and sign selection. After them comes a stream of random operations with random gaps.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Significand operation chosen by comparing the effective signs.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Result-forming case picked in the normalization segment.
    typedef enum logic [1:0] {
        NORM_LEFT  = 2'd0,
        NORM_CARRY = 2'd1,
        NORM_ZERO  = 2'd2,
        NORM_FLUSH = 2'd3
    } norm_case_e;

endpackage

// File: rtl/fpa_barrel.sv
module fpa_barrel #(
    parameter int W    = 16,
    parameter int SW   = 5,
    parameter bit LEFT = 1'b0
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);

    // One level per bit of the shift amount; level k moves by 2**k.
    logic [W-1:0] lvl [0:SW];

    assign lvl[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_level
        if (LEFT) begin : g_left
            assign lvl[k+1] = amt[k] ? (lvl[k] << (2**k)) : lvl[k];
        end else begin : g_right
            assign lvl[k+1] = amt[k] ? (lvl[k] >> (2**k)) : lvl[k];
        end
    end

    assign dout = lvl[SW];

endmodule

// File: rtl/fpa_cmp_stage.sv
module fpa_cmp_stage
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 16,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sub,
    input  logic [W-1:0]      in_a,
    input  logic [W-1:0]      in_b,
    output logic              out_vld,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [FRAC_W-1:0] out_big,
    output logic [FRAC_W-1:0] out_sml,
    output logic [EXP_W-1:0]  out_diff,
    output op_e               out_op
);

    logic                    sa, sb;
    logic [EXP_W-1:0]        ea, eb;
    logic [FRAC_W-1:0]       fa, fb;
    logic [EXP_W+FRAC_W-1:0] key_a, key_b;
    logic                    b_wins;

    logic                    sign_d;
    logic [EXP_W-1:0]        exp_d, diff_d;
    logic [FRAC_W-1:0]       big_d, sml_d;
    op_e                     op_d;

    assign sa = in_a[W-1];
    assign sb = in_b[W-1] ^ in_sub;
    assign ea = in_a[W-2 -: EXP_W];
    assign eb = in_b[W-2 -: EXP_W];
    assign fa = in_a[FRAC_W-1:0];
    assign fb = in_b[FRAC_W-1:0];

    // A zero fraction ranks below every nonzero operand, whatever its exponent.
    assign key_a  = (fa == '0) ? '0 : {ea, fa};
    assign key_b  = (fb == '0) ? '0 : {eb, fb};
    assign b_wins = (key_b > key_a);

    always_comb begin
        if (b_wins) begin
            sign_d = sb;
            exp_d  = eb;
            big_d  = fb;
            sml_d  = fa;
            diff_d = eb - ea;
        end else begin
            sign_d = sa;
            exp_d  = ea;
            big_d  = fa;
            sml_d  = fb;
            diff_d = ea - eb;
        end
        op_d = (sa == sb) ? OP_ADD : OP_SUB;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_sign <= 1'b0;
            out_exp  <= '0;
            out_big  <= '0;
            out_sml  <= '0;
            out_diff <= '0;
            out_op   <= OP_ADD;
        end else begin
            out_vld  <= in_vld;
            out_sign <= sign_d;
            out_exp  <= exp_d;
            out_big  <= big_d;
            out_sml  <= sml_d;
            out_diff <= diff_d;
            out_op   <= op_d;
        end
    end

    // R10: the kept exponent belongs to the operand of larger magnitude
    p_keep_exp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && fa != '0 && fb != '0 && ea != eb) |=>
            (out_exp == ($past(ea) > $past(eb) ? $past(ea) : $past(eb))));

endmodule

// File: rtl/fpa_align_stage.sv
module fpa_align_stage
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 16,
    parameter int SW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [FRAC_W-1:0] in_big,
    input  logic [FRAC_W-1:0] in_sml,
    input  logic [EXP_W-1:0]  in_diff,
    input  op_e               in_op,
    output logic              out_vld,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [FRAC_W-1:0] out_big,
    output logic [FRAC_W-1:0] out_sml,
    output op_e               out_op
);

    logic [FRAC_W-1:0] shifted;
    logic [FRAC_W-1:0] sml_d;
    logic              too_far;

    fpa_barrel #(
        .W    (FRAC_W),
        .SW   (SW),
        .LEFT (1'b0)
    ) i_rshift (
        .din  (in_sml),
        .amt  (in_diff[SW-1:0]),
        .dout (shifted)
    );

    // A gap at least as wide as the fraction leaves nothing to add.
    assign too_far = (in_diff >= EXP_W'(FRAC_W));
    assign sml_d   = too_far ? '0 : shifted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_sign <= 1'b0;
            out_exp  <= '0;
            out_big  <= '0;
            out_sml  <= '0;
            out_op   <= OP_ADD;
        end else begin
            out_vld  <= in_vld;
            out_sign <= in_sign;
            out_exp  <= in_exp;
            out_big  <= in_big;
            out_sml  <= sml_d;
            out_op   <= in_op;
        end
    end

    // R4: after alignment the smaller fraction never exceeds the larger
    p_align_le_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_sml <= out_big));

    // R5: equal exponents pass the fraction through unshifted
    p_equal_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_diff == '0) |=> (out_sml == $past(in_sml)));

endmodule

// File: rtl/fpa_sum_stage.sv
module fpa_sum_stage
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [FRAC_W-1:0] in_big,
    input  logic [FRAC_W-1:0] in_sml,
    input  op_e               in_op,
    output logic              out_vld,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [FRAC_W:0]   out_sum
);

    logic [FRAC_W:0] sum_d;

    always_comb begin
        unique case (in_op)
            OP_ADD: sum_d = {1'b0, in_big} + {1'b0, in_sml};
            OP_SUB: sum_d = {1'b0, in_big} - {1'b0, in_sml};
            default: sum_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_sign <= 1'b0;
            out_exp  <= '0;
            out_sum  <= '0;
        end else begin
            out_vld  <= in_vld;
            out_sign <= in_sign;
            out_exp  <= in_exp;
            out_sum  <= sum_d;
        end
    end

    // R6: an addition never yields less than the larger fraction
    p_add_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_ADD) |=> (out_sum >= {1'b0, $past(in_big)}));

    // R7: a subtraction never borrows past the larger fraction
    p_sub_shrink_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == OP_SUB) |=> (out_sum <= {1'b0, $past(in_big)}));

endmodule

// File: rtl/fpa_norm_stage.sv
module fpa_norm_stage
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 16,
    parameter int SW     = 5,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [FRAC_W:0]  in_sum,
    output logic             out_vld,
    output logic [W-1:0]     out_res
);

    logic [SW-1:0]     lz;
    logic [EXP_W-1:0]  lz_ext;
    logic [FRAC_W-1:0] shl;
    logic              seen_one;
    norm_case_e        ncase;
    logic [W-1:0]      res_d;

    // Leading-zero count of the low FRAC_W bits of the sum.
    always_comb begin
        lz       = '0;
        seen_one = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!seen_one) begin
                if (in_sum[i]) begin
                    seen_one = 1'b1;
                end else begin
                    lz = lz + 1'b1;
                end
            end
        end
    end

    assign lz_ext = {{(EXP_W - SW){1'b0}}, lz};

    fpa_barrel #(
        .W    (FRAC_W),
        .SW   (SW),
        .LEFT (1'b1)
    ) i_lshift (
        .din  (in_sum[FRAC_W-1:0]),
        .amt  (lz),
        .dout (shl)
    );

    // Case selection: which way the result word is formed.
    always_comb begin
        if (in_sum == '0) begin
            ncase = NORM_ZERO;
        end else if (in_sum[FRAC_W]) begin
            ncase = NORM_CARRY;
        end else if (in_exp < lz_ext) begin
            ncase = NORM_FLUSH;
        end else begin
            ncase = NORM_LEFT;
        end
    end

    // Result word for each case.
    always_comb begin
        unique case (ncase)
            NORM_ZERO:  res_d = '0;
            NORM_FLUSH: res_d = '0;
            NORM_CARRY: res_d = {in_sign, in_exp + 1'b1, in_sum[FRAC_W:1]};
            NORM_LEFT:  res_d = {in_sign, in_exp - lz_ext, shl};
            default:    res_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
        end else begin
            out_vld <= in_vld;
            out_res <= in_vld ? res_d : '0;
        end
    end

    // R12: a nonzero valid result is normalized
    p_norm_msb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_res[FRAC_W-1:0] != '0) |-> out_res[FRAC_W-1]);

    // R8: a zero fraction comes with zero sign and zero exponent
    p_zero_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_res[FRAC_W-1:0] == '0) |-> (out_res == '0));

    // R6: a carry raises the exponent by exactly one
    p_carry_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_sum[FRAC_W]) |=>
            (out_res[W-2 -: EXP_W] == EXP_W'($past(in_exp) + 1'b1)));

endmodule

// File: rtl/fpa_pipe4.sv
module fpa_pipe4
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 16,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SW    = $clog2(FRAC_W) + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic         in_sub,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_vld,
    output logic [W-1:0] out_res
);

    // Segment 1 -> 2
    logic              c_vld, c_sign;
    logic [EXP_W-1:0]  c_exp, c_diff;
    logic [FRAC_W-1:0] c_big, c_sml;
    op_e               c_op;

    // Segment 2 -> 3
    logic              a_vld, a_sign;
    logic [EXP_W-1:0]  a_exp;
    logic [FRAC_W-1:0] a_big, a_sml;
    op_e               a_op;

    // Segment 3 -> 4
    logic              s_vld, s_sign;
    logic [EXP_W-1:0]  s_exp;
    logic [FRAC_W:0]   s_sum;

    fpa_cmp_stage #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) i_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_sub   (in_sub),
        .in_a     (in_a),
        .in_b     (in_b),
        .out_vld  (c_vld),
        .out_sign (c_sign),
        .out_exp  (c_exp),
        .out_big  (c_big),
        .out_sml  (c_sml),
        .out_diff (c_diff),
        .out_op   (c_op)
    );

    fpa_align_stage #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .SW     (SW)
    ) i_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (c_vld),
        .in_sign  (c_sign),
        .in_exp   (c_exp),
        .in_big   (c_big),
        .in_sml   (c_sml),
        .in_diff  (c_diff),
        .in_op    (c_op),
        .out_vld  (a_vld),
        .out_sign (a_sign),
        .out_exp  (a_exp),
        .out_big  (a_big),
        .out_sml  (a_sml),
        .out_op   (a_op)
    );

    fpa_sum_stage #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) i_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (a_vld),
        .in_sign  (a_sign),
        .in_exp   (a_exp),
        .in_big   (a_big),
        .in_sml   (a_sml),
        .in_op    (a_op),
        .out_vld  (s_vld),
        .out_sign (s_sign),
        .out_exp  (s_exp),
        .out_sum  (s_sum)
    );

    fpa_norm_stage #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .SW     (SW)
    ) i_norm (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s_vld),
        .in_sign (s_sign),
        .in_exp  (s_exp),
        .in_sum  (s_sum),
        .out_vld (out_vld),
        .out_res (out_res)
    );

    // R3: every valid result was accepted four clocks earlier
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 4));

    // R11: no valid result can appear in the first clock after reset
    p_reset_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_vld);

endmodule

// File: tb/test_fpa_pipe4.sv
module test_fpa_pipe4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld, in_sub;
    logic [24:0] in_a, in_b;
    logic        out_vld;
    logic [24:0] out_res;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bit          vq[$];
    logic [24:0] rq[$];
    string       tq[$];

    always #2 clk = ~clk;

    fpa_pipe4 i_fpa_pipe4 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_sub  (in_sub),
        .in_a    (in_a),
        .in_b    (in_b),
        .out_vld (out_vld),
        .out_res (out_res)
    );

    function automatic logic [24:0] mk(bit s, int e, int f);
        return {s, 8'(e), 16'(f)};
    endfunction

    // Behavioural model of the requirements, in plain integers.
    function automatic logic [24:0] model(logic [24:0] a, logic [24:0] b, bit sub);
        int ea, eb, fa, fb, ka, kb, eg, es, fg, fs, d, sal, s, lz;
        bit sa, sb, sg, ss;
        sa = a[24];
        sb = b[24] ^ sub;
        ea = int'(a[23:16]);
        eb = int'(b[23:16]);
        fa = int'(a[15:0]);
        fb = int'(b[15:0]);
        ka = (fa == 0) ? 0 : ea * 65536 + fa;
        kb = (fb == 0) ? 0 : eb * 65536 + fb;
        if (kb > ka) begin
            sg = sb; eg = eb; fg = fb; ss = sa; es = ea; fs = fa;
        end else begin
            sg = sa; eg = ea; fg = fa; ss = sb; es = eb; fs = fb;
        end
        d   = eg - es;
        sal = (d < 0 || d >= 16) ? 0 : (fs >> d);
        s   = (sg == ss) ? fg + sal : fg - sal;
        if (s == 0) return '0;
        if (s >= 65536) return mk(sg, eg + 1, s >> 1);
        lz = 0;
        while (s < 32768) begin
            s  = s * 2;
            lz = lz + 1;
        end
        if (lz > eg) return '0;
        return mk(sg, eg - lz, s);
    endfunction

    task automatic check(bit ok, string req, logic [24:0] act, logic [24:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: compare the result due now, then drive the next input.
    task automatic step(bit v, bit sub, logic [24:0] a, logic [24:0] b, string tag);
        @(negedge clk);
        if (vq.size() == 4) begin
            bit          ev;
            logic [24:0] er;
            string       et;
            ev = vq.pop_front();
            er = rq.pop_front();
            et = tq.pop_front();
            check(out_vld == ev, "R3 valid timing", 25'(out_vld), 25'(ev));
            if (ev) begin
                check(out_res == er, et, out_res, er);
                if (out_res[15:0] != 16'h0)
                    check(out_res[15], "R12 normalized", out_res, er);
            end
        end
        in_vld = v;
        in_sub = sub;
        in_a   = a;
        in_b   = b;
        vq.push_back(v);
        rq.push_back(v ? model(a, b, sub) : 25'h0);
        tq.push_back(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        in_vld = 1'b0;
        in_sub = 1'b0;
        in_a   = '0;
        in_b   = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(out_vld == 1'b0, "R11 reset valid", 25'(out_vld), 25'h0);
        check(out_res == 25'h0, "R11 reset result", out_res, 25'h0);
        rst_n = 1'b1;

        // R5, R6: equal exponents, carry -> 0.5*2^4
        step(1, 0, mk(0, 3, 16'h8000), mk(0, 3, 16'h8000), "R6 carry");
        if (model(mk(0, 3, 16'h8000), mk(0, 3, 16'h8000), 0) != mk(0, 4, 16'h8000))
            check(0, "R6 model", 25'h0, 25'h0);
        // R4: gap of 2, shift right
        step(1, 0, mk(0, 5, 16'hC000), mk(0, 3, 16'h8000), "R4 align gap 2");
        // R4: gap of 20, no contribution
        step(1, 0, mk(0, 30, 16'h8000), mk(0, 10, 16'hFFFF), "R4 align gap 20");
        // R4: truncation of shifted-out bits
        step(1, 0, mk(0, 9, 16'h8000), mk(0, 8, 16'h8001), "R4 truncate");
        // R8: exact cancellation
        step(1, 1, mk(1, 40, 16'hA5A5), mk(1, 40, 16'hA5A5), "R8 cancel");
        // R7: leading zeros 15 -> exponent 20-15
        step(1, 1, mk(0, 20, 16'h8001), mk(0, 20, 16'h8000), "R7 left shift");
        // R9: leading zeros 15 > exponent 10 -> flush
        step(1, 1, mk(0, 10, 16'h8001), mk(0, 10, 16'h8000), "R9 flush");
        // R10: B larger, subtract -> negative result
        step(1, 1, mk(0, 4, 16'h8000), mk(0, 5, 16'h8000), "R10 sign of larger");
        // R2: add with negative B behaves as subtraction
        step(1, 0, mk(0, 6, 16'hF000), mk(1, 6, 16'h1000), "R2 add negative");
        // R2: subtract negative B behaves as addition
        step(1, 1, mk(0, 6, 16'h8000), mk(1, 6, 16'h8000), "R2 sub negative");
        // R1: zero operand with large exponent
        step(1, 0, mk(0, 7, 16'h9000), mk(1, 200, 16'h0000), "R1 zero operand");
        // R10: equal magnitudes, opposite effective signs after add -> zero
        step(1, 0, mk(1, 12, 16'hC000), mk(0, 12, 16'hC000), "R10 equal mag");
        // R3: gap, then back-to-back stream
        step(0, 0, '0, '0, "R3 idle");
        for (int i = 0; i < 400; i++) begin
            int  ea, eb;
            bit  v;
            ea = 20 + int'($urandom_range(0, 180));
            eb = ($urandom_range(0, 3) == 0) ? ea : 20 + int'($urandom_range(0, 180));
            if ($urandom_range(0, 3) == 0) eb = ea + int'($urandom_range(0, 4)) - 2;
            v  = ($urandom_range(0, 4) != 0);
            step(v, 1'($urandom_range(0, 1)),
                 mk(1'($urandom_range(0, 1)), ea, 16'h8000 | 16'($urandom())),
                 mk(1'($urandom_range(0, 1)), eb, 16'h8000 | 16'($urandom())),
                 "R3 R2 random stream");
        end
        for (int i = 0; i < 5; i++) step(0, 0, '0, '0, "R3 drain");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule